// File: doc/BRIEF.md
# Bridge Exclusive-Access Lock Tracker

This block watches the LOCK# protocol on both sides of a bus-to-bus bridge. It follows the primary bus phases and recognises the start of a locked sequence. It then decides whether the sequence has to cross the bridge, and keeps the secondary bus locked on behalf of the primary master for as long as that master holds its lock. The two buses keep their locks independently, except when a locked sequence crosses the bridge. Locks only ever cross downstream, from primary to secondary.

A locked sequence may begin only from an idle primary bus with LOCK# deasserted. The master keeps LOCK# high through the address phase and pulls it low on the next clock. The lock counts as established only after the first data transfer completes. If that first transaction ends with no data moved, for example after a retry or an abort, nothing is locked. When the target sits behind the bridge, the block raises a forwarding request, claims the secondary LOCK# once the secondary bus is idle and unlocked, and answers secondary masters trying to reach through the bridge with a retry indication. Releasing needs both LOCK# and FRAME# deasserted on the primary side. The secondary LOCK# is then let go on the next idle secondary cycle.

Top module: `lock_bridge_tracker`

## Requirements
- R1: After reset, `fwd_lock_req`, `p_lock_held`, `s_lock_drive` and `s_retry` are all 0.
- R2: A locked sequence starts only if LOCK# (`p_lock_n`) was sampled high, and the bus was sampled idle (FRAME# and IRDY# both high), on the clock before the address phase. An address phase that follows a low LOCK# never raises `fwd_lock_req` or `p_lock_held`.
- R3: If LOCK# is not sampled low on the clock after the address phase, the transaction is ordinary: `fwd_lock_req` and `p_lock_held` stay 0, even after data transfers.
- R4: For a locked start to a target behind the bridge (`p_behind` = 1 in the address phase), `fwd_lock_req` is 1 after the edge that samples LOCK# low. `p_lock_held` becomes 1, and `fwd_lock_req` returns to 0, after the edge that samples IRDY# and TRDY# both low.
- R5: If the first locked transaction returns to idle with no data transfer, `fwd_lock_req` and `p_lock_held` are 0 after that edge. Any secondary LOCK# claimed for it is released on the next edge at which `s_idle` is 1.
- R6: A locked sequence to a primary-side target (`p_behind` = 0) sets `p_lock_held` but never raises `fwd_lock_req`, `s_lock_drive` or `s_retry`.
- R7: `s_lock_drive` rises only on an edge where `fwd_lock_req` is 1, `s_idle` is 1 and `s_lock_n` is 1. While another secondary master holds `s_lock_n` low, it waits.
- R8: `p_lock_held` clears after the first edge that samples `p_lock_n` and `p_frame_n` both high. LOCK# low on an idle bus, or LOCK# high during a new address phase, keeps the lock.
- R9: After the primary lock clears, `s_lock_drive` stays 1 until the first later edge at which `s_idle` is 1, and is 0 after that edge.
- R10: `s_retry` equals `s_up_req` while `s_lock_drive` is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both bus monitors |
| rst_n | input | 1 | Synchronous reset, active low |
| p_frame_n | input | 1 | Primary FRAME#, active low |
| p_irdy_n | input | 1 | Primary IRDY#, active low |
| p_trdy_n | input | 1 | Primary TRDY#, active low |
| p_lock_n | input | 1 | Primary LOCK#, active low |
| p_behind | input | 1 | Decoded: current primary address targets the secondary side |
| s_idle | input | 1 | Secondary bus idle this cycle |
| s_lock_n | input | 1 | Secondary LOCK# as driven by other masters, active low |
| s_up_req | input | 1 | A secondary master is addressing through the bridge |
| fwd_lock_req | output | 1 | Request to forward the first locked transaction downstream |
| s_lock_drive | output | 1 | Bridge drives secondary LOCK# asserted |
| p_lock_held | output | 1 | Primary lock established |
| s_retry | output | 1 | Retry the current upstream secondary request |

## Verification
The hardest case to reach is a claimed secondary lock that is left behind when the first locked transaction fails. The secondary claim only happens one edge after the forwarding request rises, so the target retry has to land just after that edge. The bench holds the first transaction in a data phase with no TRDY# for one clock, then drops the bus to idle. It then checks that the secondary LOCK# is dropped one edge later. A second case keeps the secondary bus busy across the primary release, to show that the drive lasts until an idle secondary cycle.

// File: rtl/lock_tracker_pkg.sv
// Package: shared state encoding for the bridge lock tracker.
// Assumes: a single clock domain for both bus sides.
package lock_tracker_pkg;
    typedef enum logic [1:0] {
        LK_FREE  = 2'd0,   // no lock activity
        LK_ARMED = 2'd1,   // address phase seen with LOCK# high on an idle bus
        LK_FIRST = 2'd2,   // LOCK# asserted, first data transfer pending
        LK_HELD  = 2'd3    // lock established
    } lk_state_t;
endpackage

// File: rtl/pbus_phase_mon.sv
// Module: primary bus phase monitor.
// Finds address phases that may open a locked sequence, data transfers
// and idle cycles. Assumes the active-low bus signals are already sampled.
module pbus_phase_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic p_frame_n,
    input  logic p_irdy_n,
    input  logic p_trdy_n,
    input  logic p_lock_n,
    output logic lock_start_ok,
    output logic data_xfer,
    output logic bus_idle
);
    logic prev_idle;
    logic prev_lock_n;

    assign bus_idle      = p_frame_n & p_irdy_n;
    assign data_xfer     = ~p_irdy_n & ~p_trdy_n;
    // address phase: FRAME# newly asserted on a previously idle, unlocked bus
    assign lock_start_ok = ~p_frame_n & prev_idle & prev_lock_n & p_lock_n;

    // Remember bus idle and LOCK# state of the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_idle   <= 1'b1;
            prev_lock_n <= 1'b1;
        end else begin
            prev_idle   <= bus_idle;
            prev_lock_n <= p_lock_n;
        end
    end
endmodule

// File: rtl/lock_seq_fsm.sv
// Module: primary lock sequence tracker.
// Follows start, establishment and release of a primary lock, and
// records whether it crosses the bridge. Assumes p_behind is valid
// in the address phase.
module lock_seq_fsm
    import lock_tracker_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lock_start_ok,
    input  logic data_xfer,
    input  logic bus_idle,
    input  logic p_lock_n,
    input  logic p_frame_n,
    input  logic p_behind,
    output logic fwd_req,
    output logic held,
    output logic hold_down
);
    lk_state_t state, state_nx;
    logic      downstream;

    // Next-state decision for the lock sequence.
    always_comb begin
        state_nx = state;
        unique case (state)
            LK_FREE:  if (lock_start_ok) state_nx = LK_ARMED;
            LK_ARMED: state_nx = p_lock_n ? LK_FREE : LK_FIRST;
            LK_FIRST: begin
                if (data_xfer)     state_nx = LK_HELD;
                else if (bus_idle) state_nx = LK_FREE;
            end
            LK_HELD:  if (p_lock_n && p_frame_n) state_nx = LK_FREE;
            default:  state_nx = LK_FREE;
        endcase
    end

    // State register and capture of the crossing direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= LK_FREE;
            downstream <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == LK_FREE && lock_start_ok)
                downstream <= p_behind;
        end
    end

    assign fwd_req   = (state == LK_FIRST) & downstream;
    assign held      = (state == LK_HELD);
    assign hold_down = downstream & ((state == LK_FIRST) | (state == LK_HELD));
endmodule

// File: rtl/sec_lock_driver.sv
// Module: secondary LOCK# owner.
// Claims secondary LOCK# for a forwarded lock once that bus is idle and
// unlocked, and lets it go on the first idle cycle after the hold ends.
module sec_lock_driver (
    input  logic clk,
    input  logic rst_n,
    input  logic fwd_req,
    input  logic hold_down,
    input  logic s_idle,
    input  logic s_lock_n,
    output logic s_lock_drive
);
    // Claim and release of the secondary lock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            s_lock_drive <= 1'b0;
        else if (!s_lock_drive)
            s_lock_drive <= fwd_req & s_idle & s_lock_n;
        else if (!hold_down && s_idle)
            s_lock_drive <= 1'b0;
    end
endmodule

// File: rtl/lock_bridge_tracker.sv
// Module: bridge exclusive-access lock tracker (top).
// Joins the primary phase monitor, the lock sequence tracker and the
// secondary LOCK# owner, and retries upstream secondary requests while
// the secondary bus is held for a primary master.
module lock_bridge_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic p_frame_n,
    input  logic p_irdy_n,
    input  logic p_trdy_n,
    input  logic p_lock_n,
    input  logic p_behind,
    input  logic s_idle,
    input  logic s_lock_n,
    input  logic s_up_req,
    output logic fwd_lock_req,
    output logic s_lock_drive,
    output logic p_lock_held,
    output logic s_retry
);
    logic lock_start_ok, data_xfer, bus_idle, hold_down;

    pbus_phase_mon u_mon (
        .clk(clk), .rst_n(rst_n),
        .p_frame_n(p_frame_n), .p_irdy_n(p_irdy_n),
        .p_trdy_n(p_trdy_n), .p_lock_n(p_lock_n),
        .lock_start_ok(lock_start_ok), .data_xfer(data_xfer),
        .bus_idle(bus_idle)
    );

    lock_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .lock_start_ok(lock_start_ok), .data_xfer(data_xfer),
        .bus_idle(bus_idle), .p_lock_n(p_lock_n),
        .p_frame_n(p_frame_n), .p_behind(p_behind),
        .fwd_req(fwd_lock_req), .held(p_lock_held),
        .hold_down(hold_down)
    );

    sec_lock_driver u_sdrv (
        .clk(clk), .rst_n(rst_n),
        .fwd_req(fwd_lock_req), .hold_down(hold_down),
        .s_idle(s_idle), .s_lock_n(s_lock_n),
        .s_lock_drive(s_lock_drive)
    );

    // Upstream secondary requests bounce while the bridge holds the lock.
    assign s_retry = s_up_req & s_lock_drive;
endmodule

// File: rtl/lock_bridge_tracker_chk.sv
// Module: protocol checker for the lock tracker, bound to the top.
module lock_bridge_tracker_chk (
    input logic clk,
    input logic rst_n,
    input logic p_frame_n,
    input logic p_irdy_n,
    input logic p_trdy_n,
    input logic p_lock_n,
    input logic s_idle,
    input logic s_lock_n,
    input logic fwd_lock_req,
    input logic s_lock_drive,
    input logic p_lock_held,
    input logic s_retry
);
    a_r10_retry_only_locked: assert property (@(posedge clk) disable iff (!rst_n)
        s_retry |-> s_lock_drive);

    a_r4_fwd_after_lock_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fwd_lock_req) |-> !$past(p_lock_n));

    a_r4_held_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(p_lock_held) |-> $past(!p_irdy_n && !p_trdy_n));

    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (p_lock_held && p_lock_n && p_frame_n) |=> !p_lock_held);

    a_r7_claim_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_lock_drive) |-> $past(s_idle && s_lock_n && fwd_lock_req));

    a_r9_drop_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_lock_drive) |-> $past(s_idle));
endmodule

bind lock_bridge_tracker lock_bridge_tracker_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .p_frame_n(p_frame_n), .p_irdy_n(p_irdy_n),
    .p_trdy_n(p_trdy_n), .p_lock_n(p_lock_n),
    .s_idle(s_idle), .s_lock_n(s_lock_n),
    .fwd_lock_req(fwd_lock_req), .s_lock_drive(s_lock_drive),
    .p_lock_held(p_lock_held), .s_retry(s_retry)
);

// File: tb/test_lock_bridge_tracker.sv
module test_lock_bridge_tracker;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic p_frame_n = 1'b1, p_irdy_n = 1'b1, p_trdy_n = 1'b1, p_lock_n = 1'b1;
    logic p_behind = 1'b0, s_idle = 1'b1, s_lock_n = 1'b1, s_up_req = 1'b0;
    logic fwd_lock_req, s_lock_drive, p_lock_held, s_retry;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    lock_bridge_tracker i_lock_bridge_tracker (
        .clk(clk), .rst_n(rst_n),
        .p_frame_n(p_frame_n), .p_irdy_n(p_irdy_n), .p_trdy_n(p_trdy_n),
        .p_lock_n(p_lock_n), .p_behind(p_behind),
        .s_idle(s_idle), .s_lock_n(s_lock_n), .s_up_req(s_up_req),
        .fwd_lock_req(fwd_lock_req), .s_lock_drive(s_lock_drive),
        .p_lock_held(p_lock_held), .s_retry(s_retry)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic pbus(input logic fr, input logic ir, input logic tr, input logic lk, input logic bh);
        p_frame_n = fr; p_irdy_n = ir; p_trdy_n = tr; p_lock_n = lk; p_behind = bh;
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic go_idle;
        pbus(1, 1, 1, 1, 0); s_idle = 1; s_lock_n = 1; s_up_req = 0;
        tick; tick;
    endtask

    task automatic t_reset;
        rst_n = 0; tick; tick;
        chk("R1", "fwd_lock_req", fwd_lock_req, 0);
        chk("R1", "p_lock_held", p_lock_held, 0);
        chk("R1", "s_lock_drive", s_lock_drive, 0);
        s_up_req = 1; #1;
        chk("R1", "s_retry", s_retry, 0);
        s_up_req = 0;
        rst_n = 1; tick;
    endtask

    task automatic t_downstream;
        go_idle;
        pbus(0, 1, 1, 1, 1); tick;
        chk("R4", "fwd in addr", fwd_lock_req, 0);
        pbus(1, 0, 1, 0, 0); tick;
        chk("R4", "fwd after LOCK low", fwd_lock_req, 1);
        chk("R4", "held before data", p_lock_held, 0);
        pbus(1, 0, 0, 0, 0); tick;
        chk("R4", "held after data", p_lock_held, 1);
        chk("R4", "fwd cleared", fwd_lock_req, 0);
        chk("R7", "claimed on idle free bus", s_lock_drive, 1);
        pbus(1, 1, 1, 0, 0); tick;
        chk("R8", "kept on idle with LOCK", p_lock_held, 1);
        s_up_req = 1; #1;
        chk("R10", "retry while locked", s_retry, 1);
        pbus(0, 1, 1, 1, 0); tick;
        chk("R8", "kept in new addr phase", p_lock_held, 1);
        pbus(1, 0, 0, 0, 0); tick;
        pbus(1, 1, 1, 1, 0); s_idle = 0; tick;
        chk("R8", "released", p_lock_held, 0);
        chk("R9", "held while secondary busy", s_lock_drive, 1);
        tick;
        chk("R9", "still held, busy", s_lock_drive, 1);
        s_idle = 1; tick;
        chk("R9", "dropped on idle", s_lock_drive, 0);
        #1;
        chk("R10", "no retry after release", s_retry, 0);
        s_up_req = 0;
    endtask

    task automatic t_secondary_busy;
        go_idle;
        s_lock_n = 0;
        pbus(0, 1, 1, 1, 1); tick;
        pbus(1, 0, 1, 0, 0); tick;
        tick;
        chk("R7", "wait for other lock", s_lock_drive, 0);
        chk("R7", "fwd still pending", fwd_lock_req, 1);
        s_lock_n = 1; tick;
        chk("R7", "claimed once free", s_lock_drive, 1);
        pbus(1, 0, 0, 0, 0); tick;
        pbus(1, 1, 1, 1, 0); tick;
        chk("R8", "released", p_lock_held, 0);
        chk("R9", "drive lasts one edge", s_lock_drive, 1);
        tick;
        chk("R9", "dropped next idle edge", s_lock_drive, 0);
    endtask

    task automatic t_failed_first;
        go_idle;
        pbus(0, 1, 1, 1, 1); tick;
        pbus(1, 0, 1, 0, 0); tick;
        chk("R5", "fwd raised", fwd_lock_req, 1);
        pbus(1, 1, 1, 1, 0); tick;
        chk("R5", "fwd cleared", fwd_lock_req, 0);
        chk("R5", "not held", p_lock_held, 0);
        chk("R5", "claim pending release", s_lock_drive, 1);
        tick;
        chk("R5", "secondary released", s_lock_drive, 0);
    endtask

    task automatic t_ordinary;
        go_idle;
        pbus(0, 1, 1, 1, 1); tick;
        pbus(1, 0, 1, 1, 0); tick;
        chk("R3", "no fwd", fwd_lock_req, 0);
        pbus(1, 0, 0, 0, 0); tick;
        chk("R3", "no hold", p_lock_held, 0);
        chk("R3", "no secondary lock", s_lock_drive, 0);
    endtask

    task automatic t_busy_lock;
        go_idle;
        pbus(1, 1, 1, 0, 0); tick;
        pbus(0, 1, 1, 1, 1); tick;
        pbus(1, 0, 1, 0, 0); tick;
        chk("R2", "no fwd after LOCK low", fwd_lock_req, 0);
        pbus(1, 0, 0, 0, 0); tick;
        chk("R2", "no hold", p_lock_held, 0);
    endtask

    task automatic t_local;
        go_idle;
        s_up_req = 1;
        pbus(0, 1, 1, 1, 0); tick;
        pbus(1, 0, 1, 0, 0); tick;
        chk("R6", "no fwd", fwd_lock_req, 0);
        pbus(1, 0, 0, 0, 0); tick;
        chk("R6", "primary held", p_lock_held, 1);
        chk("R6", "no secondary lock", s_lock_drive, 0);
        chk("R6", "no retry", s_retry, 0);
        pbus(1, 1, 1, 1, 0); tick;
        chk("R8", "local released", p_lock_held, 0);
        s_up_req = 0;
    endtask

    initial begin
        fork
            begin
                t_reset;
                t_downstream;
                t_secondary_busy;
                t_failed_first;
                t_ordinary;
                t_busy_lock;
                t_local;
            end
            begin
                repeat (5000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule